// File: doc/BRIEF.md
# MPEG-2 Transport Packet Sync Framer

This block receives the serial bit stream that leaves the syndrome converter of a cable downstream receiver. It looks for the transport sync byte 0x47, which recurs every 188 bytes. A gap of 1496 bits lies between the end of one sync byte and the start of the next. Each candidate position is confirmed over a programmable number of packet periods before lock is declared. While locked, the block cuts the stream into bytes that line up with the packets. It marks the first byte of every packet, and it reports a packet error whenever the sync byte is absent where it is due.

A bypass mode skips the search completely. In that mode bytes are formed from the first bit of each frame, as marked by a frame-start input. Input bits are qualified by a valid strobe, and every output is registered.

Top module: `ts_sync_framer`

## Requirements
- R1: While reset is high, and on the first clock after it, byte_vld, byte_sop, pkt_err and locked are all 0.
- R2: Bits enter MSB first. A candidate starts when the last 8 valid bits equal 0x47. Lock is declared on the bit that completes the n-th consecutive match, with each match exactly 1504 valid bits after the previous one. n is `lock_hits`, and a value of 0 counts as 1.
- R3: While a candidate is being confirmed, a mismatch at the expected position sends the block back to searching. A 0x47 that passes at any other position during confirmation is ignored.
- R4: The cycle after lock is declared, locked rises and the sync byte is output with byte_sop=1. While locked, one byte comes out for every 8 valid bits, aligned to the sync position, which gives 188 bytes per packet. byte_sop is 1 only on the byte in the sync position.
- R5: Each output byte holds its 8 bits in arrival order, with the first bit received in bit 7.
- R6: While locked, a byte other than 0x47 in the sync position is still output, with byte_sop=1 and pkt_err=1. A correct sync byte clears the count of consecutive misses.
- R7: locked falls on the same cycle as the pkt_err of the `miss_limit`-th consecutive missing sync byte. A value of 0 counts as 1.
- R8: With bypass=1, locked stays 0 and pkt_err stays 0. Valid bits before the first frame start are dropped. A frame start begins a new byte and discards any partial byte. The first byte of each frame carries byte_sop=1.
- R9: A cycle with bit_vld=0 changes neither the alignment nor the search state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | bit_in is valid this cycle |
| frame_start | input | 1 | This valid bit is the first bit of a frame |
| bypass | input | 1 | 1: frame-aligned packing with no sync search |
| lock_hits | input | 4 | Consecutive sync matches needed for lock |
| miss_limit | input | 4 | Consecutive missing syncs that drop lock |
| byte_out | output | 8 | Output byte, first bit received in bit 7 |
| byte_vld | output | 1 | byte_out is valid |
| byte_sop | output | 1 | Byte is the first byte of a packet or frame |
| locked | output | 1 | Packet sync is declared |
| pkt_err | output | 1 | Expected sync byte was missing |

## Verification
The hardest case to reach is a false 0x47 in the data that captures the search while the real stream passes underneath it. The stimulus places one stray sync byte 50 bytes ahead of the real packets. This keeps the block confirming the wrong position while the first real sync goes by. The bench then checks that lock arrives one packet later than it would have without the stray byte. The miss counter is exercised by alternating bad and good sync bytes, so that only two misses in a row can drop lock.

// File: rtl/ts_framer_pkg.sv
package ts_framer_pkg;
  typedef enum logic [1:0] {
    TRK_SEARCH = 2'd0,
    TRK_VERIFY = 2'd1,
    TRK_LOCK   = 2'd2
  } trk_state_e;
endpackage

// File: rtl/ts_bit_window.sv
// Sliding window over the last W valid bits, MSB first, with pattern compare.
module ts_bit_window #(
  parameter int W = 8,
  parameter logic [W-1:0] PATTERN = 8'h47,
  localparam int FW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  input  logic         bit_vld,
  output logic [W-1:0] win_nxt,
  output logic         match
);
  logic [W-1:0]  win_q;
  logic [FW-1:0] fill_q;

  assign win_nxt = {win_q[W-2:0], bit_in};
  // match only once a full window of real bits has been seen
  assign match   = bit_vld && (fill_q == FW'(W-1)) && (win_nxt == PATTERN);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      win_q <= win_nxt;
      if (fill_q != FW'(W-1)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/ts_sync_tracker.sv
// Search / confirm / lock state machine with packet bit position.
module ts_sync_tracker
  import ts_framer_pkg::*;
#(
  parameter int PKT_BITS = 1504,
  parameter int CNT_W    = 4,
  localparam int POS_W   = $clog2(PKT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bypass,
  input  logic             match,
  input  logic [CNT_W-1:0] lock_hits,
  input  logic [CNT_W-1:0] miss_limit,
  output logic             locked,
  output logic             aln_emit,
  output logic             aln_sop,
  output logic             aln_err
);
  localparam logic [POS_W-1:0] LAST = POS_W'(PKT_BITS - 1);

  trk_state_e       st_q, st_n;
  logic [POS_W-1:0] pos_q, pos_n, pos_inc;
  logic [CNT_W-1:0] hits_q, hits_n, miss_q, miss_n;
  logic [CNT_W-1:0] need, lim;
  logic [CNT_W:0]   hits_p1, miss_p1;

  assign need    = (lock_hits  == '0) ? CNT_W'(1) : lock_hits;
  assign lim     = (miss_limit == '0) ? CNT_W'(1) : miss_limit;
  assign pos_inc = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  assign hits_p1 = {1'b0, hits_q} + 1'b1;
  assign miss_p1 = {1'b0, miss_q} + 1'b1;
  assign locked  = (st_q == TRK_LOCK);

  always_comb begin
    st_n     = st_q;
    pos_n    = pos_q;
    hits_n   = hits_q;
    miss_n   = miss_q;
    aln_emit = 1'b0;
    aln_sop  = 1'b0;
    aln_err  = 1'b0;
    if (bypass) begin
      st_n   = TRK_SEARCH;
      pos_n  = '0;
      hits_n = '0;
      miss_n = '0;
    end else if (bit_vld) begin
      unique case (st_q)
        TRK_SEARCH: begin
          if (match) begin
            pos_n  = '0;
            hits_n = CNT_W'(1);
            miss_n = '0;
            if (need == CNT_W'(1)) begin
              st_n     = TRK_LOCK;
              aln_emit = 1'b1;
              aln_sop  = 1'b1;
            end else begin
              st_n = TRK_VERIFY;
            end
          end
        end
        TRK_VERIFY: begin
          pos_n = pos_inc;
          if (pos_q == LAST) begin
            if (match) begin
              hits_n = hits_p1[CNT_W-1:0];
              if (hits_p1 >= {1'b0, need}) begin
                st_n     = TRK_LOCK;
                miss_n   = '0;
                aln_emit = 1'b1;
                aln_sop  = 1'b1;
              end
            end else begin
              st_n   = TRK_SEARCH;
              hits_n = '0;
            end
          end
        end
        TRK_LOCK: begin
          pos_n = pos_inc;
          if (pos_inc[2:0] == 3'd0) aln_emit = 1'b1;
          if (pos_q == LAST) begin
            aln_sop = 1'b1;
            if (match) begin
              miss_n = '0;
            end else begin
              aln_err = 1'b1;
              if (miss_p1 >= {1'b0, lim}) begin
                st_n   = TRK_SEARCH;
                miss_n = '0;
                hits_n = '0;
              end else begin
                miss_n = miss_p1[CNT_W-1:0];
              end
            end
          end
        end
        default: st_n = TRK_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TRK_SEARCH;
      pos_q  <= '0;
      hits_q <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_n;
      pos_q  <= pos_n;
      hits_q <= hits_n;
      miss_q <= miss_n;
    end
  end

  assert_lock_needs_match_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(match));
  assert_miss_below_limit_R7: assert property (@(posedge clk) disable iff (rst)
    locked |-> (miss_q < lim));
  assert_bypass_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
    bypass |=> !locked);
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !bypass) |=> ($stable(pos_q) && $stable(st_q)));
endmodule

// File: rtl/ts_byte_packer.sv
// Registered byte output for both aligned and frame-bypass packing.
module ts_byte_packer #(
  parameter int W = 8,
  localparam int BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bypass,
  input  logic         bit_vld,
  input  logic         frame_start,
  input  logic [W-1:0] win_nxt,
  input  logic         aln_emit,
  input  logic         aln_sop,
  input  logic         aln_err,
  output logic [W-1:0] byte_out,
  output logic         byte_vld,
  output logic         byte_sop,
  output logic         pkt_err
);
  logic          framed_q, first_q;
  logic [BW-1:0] bcnt_q;
  logic          byp_emit;

  assign byp_emit = bypass && bit_vld && !frame_start && framed_q &&
                    (bcnt_q == BW'(W-1));

  always_ff @(posedge clk) begin
    if (rst || !bypass) begin
      framed_q <= 1'b0;
      first_q  <= 1'b0;
      bcnt_q   <= '0;
    end else if (bit_vld) begin
      if (frame_start) begin
        framed_q <= 1'b1;
        first_q  <= 1'b1;
        bcnt_q   <= BW'(1);
      end else if (framed_q) begin
        bcnt_q <= bcnt_q + 1'b1;
        if (bcnt_q == BW'(W-1)) first_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out <= '0;
      byte_vld <= 1'b0;
      byte_sop <= 1'b0;
      pkt_err  <= 1'b0;
    end else begin
      byte_vld <= byp_emit || (!bypass && aln_emit);
      byte_sop <= bypass ? (byp_emit && first_q) : (aln_emit && aln_sop);
      pkt_err  <= !bypass && aln_emit && aln_err;
      if (byp_emit || (!bypass && aln_emit)) byte_out <= win_nxt;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!byte_vld && !byte_sop && !pkt_err));
  assert_err_with_sop_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_err |-> (byte_sop && byte_vld));
  assert_bypass_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    bypass |=> !pkt_err);
endmodule

// File: rtl/ts_sync_framer.sv
module ts_sync_framer #(
  parameter int          PKT_BITS = 1504,
  parameter int          CNT_W    = 4,
  parameter logic [7:0]  SYNC     = 8'h47
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic             frame_start,
  input  logic             bypass,
  input  logic [CNT_W-1:0] lock_hits,
  input  logic [CNT_W-1:0] miss_limit,
  output logic [7:0]       byte_out,
  output logic             byte_vld,
  output logic             byte_sop,
  output logic             locked,
  output logic             pkt_err
);
  logic [7:0] win_nxt;
  logic       match, aln_emit, aln_sop, aln_err, trk_locked;

  ts_bit_window #(.W(8), .PATTERN(SYNC)) u_win (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .win_nxt(win_nxt), .match(match)
  );

  ts_sync_tracker #(.PKT_BITS(PKT_BITS), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bypass(bypass), .match(match),
    .lock_hits(lock_hits), .miss_limit(miss_limit), .locked(trk_locked),
    .aln_emit(aln_emit), .aln_sop(aln_sop), .aln_err(aln_err)
  );

  ts_byte_packer #(.W(8)) u_pack (
    .clk(clk), .rst(rst), .bypass(bypass), .bit_vld(bit_vld),
    .frame_start(frame_start), .win_nxt(win_nxt), .aln_emit(aln_emit),
    .aln_sop(aln_sop), .aln_err(aln_err), .byte_out(byte_out),
    .byte_vld(byte_vld), .byte_sop(byte_sop), .pkt_err(pkt_err)
  );

  assign locked = trk_locked;
endmodule

// File: tb/ts_sync_framer_bench.sv
module ts_sync_framer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0, bit_vld = 1'b0, frame_start = 1'b0, bypass = 1'b0;
  logic [3:0] lock_hits = 4'd3, miss_limit = 4'd2;
  logic [7:0] byte_out;
  logic       byte_vld, byte_sop, locked, pkt_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] q_byte[$];
  logic       q_sop[$];
  logic       q_err[$];

  always #10 clk = ~clk;

  ts_sync_framer u_ts_sync_framer (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .frame_start(frame_start), .bypass(bypass), .lock_hits(lock_hits),
    .miss_limit(miss_limit), .byte_out(byte_out), .byte_vld(byte_vld),
    .byte_sop(byte_sop), .locked(locked), .pkt_err(pkt_err)
  );

  always @(posedge clk) begin
    #1;
    if (byte_vld) begin
      q_byte.push_back(byte_out);
      q_sop.push_back(byte_sop);
      q_err.push_back(pkt_err);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_q();
    q_byte.delete(); q_sop.delete(); q_err.delete();
  endtask

  task automatic send_bit(input logic b, input logic fs);
    @(negedge clk);
    bit_in = b; frame_start = fs; bit_vld = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bit_vld = 1'b0; frame_start = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic fs);
    for (int i = 7; i >= 0; i--) send_bit(b[i], fs && (i == 7));
  endtask

  // payload bytes never contain three ones in a row, so no stray 0x47 appears
  function automatic logic [7:0] pay(input int k);
    return k[0] ? 8'hA5 : 8'h12;
  endfunction

  task automatic send_payload(input int from, input int to);
    for (int k = from; k <= to; k++) send_byte(pay(k), 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0; frame_start = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 byte_vld in reset", byte_vld, 0);
    chk("R1 locked in reset", locked, 0);
    chk("R1 sop/err in reset", {byte_sop, pkt_err}, 0);
    @(negedge clk); rst = 1'b0;
    clear_q();
  endtask

  task automatic t_lock_and_misses();
    int bad;
    lock_hits = 4'd3; miss_limit = 4'd2; bypass = 1'b0;
    do_reset();
    send_byte(8'h47, 0); send_payload(1, 187);
    send_byte(8'h47, 0); send_payload(1, 187);
    chk("R2 not locked after two matches", locked, 0);
    chk("R2 no bytes before lock", q_byte.size(), 0);
    send_byte(8'h47, 0);
    chk("R2 locked on third match", locked, 1);
    chk("R4 sync byte out with sop", {byte_vld, byte_sop, pkt_err, byte_out}, {3'b110, 8'h47});
    send_payload(1, 93);
    idle(5);
    chk("R9 lock kept over idle gap", locked, 1);
    send_payload(94, 187);
    chk("R4 R9 bytes per packet", q_byte.size(), 188);
    bad = 0;
    for (int k = 0; k < q_byte.size(); k++) begin
      if (q_sop[k] !== (k == 0)) bad++;
      if (q_err[k] !== 1'b0) bad++;
      if (q_byte[k] !== ((k == 0) ? 8'h47 : pay(k))) bad++;
    end
    chk("R5 R4 packet byte content and sop", bad, 0);
    send_byte(8'h00, 0);
    chk("R6 missing sync flagged", {byte_vld, byte_sop, pkt_err, byte_out}, {3'b111, 8'h00});
    chk("R6 lock kept after one miss", locked, 1);
    send_payload(1, 187);
    send_byte(8'h47, 0);
    chk("R6 good sync no error", {byte_sop, pkt_err}, 2'b10);
    send_payload(1, 187);
    send_byte(8'h00, 0);
    chk("R6 miss after good sync keeps lock", {pkt_err, locked}, 2'b11);
    send_payload(1, 187);
    send_byte(8'h00, 0);
    chk("R7 second consecutive miss drops lock", {byte_vld, pkt_err, locked}, 3'b110);
    idle(2);
  endtask

  task automatic t_zero_hits();
    lock_hits = 4'd0; miss_limit = 4'd2; bypass = 1'b0;
    do_reset();
    send_payload(1, 5);
    send_byte(8'h47, 0);
    chk("R2 zero hit count locks on first match", {locked, byte_vld, byte_sop}, 3'b111);
    idle(2);
    do_reset();
  endtask

  task automatic t_false_candidate();
    lock_hits = 4'd2; miss_limit = 4'd2; bypass = 1'b0;
    do_reset();
    send_byte(8'h47, 0);
    send_payload(1, 50);
    send_byte(8'h47, 0); send_payload(1, 187);
    send_byte(8'h47, 0);
    chk("R3 stray sync delays lock", locked, 0);
    send_payload(1, 187);
    send_byte(8'h47, 0);
    chk("R3 lock after restart", {locked, byte_sop}, 2'b11);
    idle(2);
  endtask

  task automatic t_bypass();
    lock_hits = 4'd1; miss_limit = 4'd1; bypass = 1'b1;
    do_reset();
    send_bit(1, 0); send_bit(1, 0); send_bit(1, 0);
    send_byte(8'hC3, 1);
    send_byte(8'h47, 0);
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0); send_bit(0, 0);
    send_byte(8'h99, 1);
    send_byte(8'h47, 0);
    idle(2);
    chk("R8 bypass byte count", q_byte.size(), 4);
    if (q_byte.size() == 4) begin
      chk("R8 frame byte 0", {q_sop[0], q_err[0], q_byte[0]}, {2'b10, 8'hC3});
      chk("R8 frame byte 1", {q_sop[1], q_err[1], q_byte[1]}, {2'b00, 8'h47});
      chk("R8 restart drops partial", {q_sop[2], q_err[2], q_byte[2]}, {2'b10, 8'h99});
      chk("R8 frame byte 3", {q_sop[3], q_err[3], q_byte[3]}, {2'b00, 8'h47});
    end
    chk("R8 never locked in bypass", locked, 0);
    bypass = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    chk("R1 outputs idle in reset", {byte_vld, byte_sop, locked, pkt_err}, 0);
    t_lock_and_misses();
    t_zero_hits();
    t_false_candidate();
    t_bypass();
    finish_run();
  end
endmodule